// File: doc/BRIEF.md
# Spatial Generation Training Table

This block learns which cache blocks of a spatial region are touched between the first touch of the region and the moment any touched block leaves the primary data cache. A region is an aligned group of 2^OFF_W consecutive cache blocks. The block watches two input streams. The first carries data accesses, each a block address with the PC of the instruction. The second carries removals, each the block address of a line that was evicted or invalidated. Both kinds of removal are handled the same way. When a generation ends, the block sends out its record: the PC and offset of the trigger access, plus a bit vector of the touched blocks. The record goes to a downstream history store.

Training runs in two associative tables. The filter table holds regions that have seen only one distinct block so far, so these cost no pattern storage. The accumulation table holds regions with two or more distinct blocks, together with their patterns. When a second distinct block in a region is touched, its filter entry moves to the accumulation table. If a table is full when a new entry is needed, a victim is chosen round-robin. A filter victim is dropped. An accumulation victim is sent out as a completed record.

The commit port uses a valid/ready handshake. While a record waits on it, the shared input ready is low. A small state machine controls this. ST_IDLE accepts inputs. It moves to ST_SEND in the cycle in which the processed inputs produce a record. ST_SEND holds the record and returns to ST_IDLE in the cycle in which cm_ready is high.

Top module: `sgen_train`

## Requirements
- R1: After reset, in_ready is 1, cm_valid is 0, and both tables are empty.
- R2: A block address splits into a region tag (bits above OFF_W) and a block offset (the low OFF_W bits). Bit i of a pattern stands for offset i. An access whose region is in the accumulation table sets that region's bit for the access offset. Setting a bit that is already set changes nothing.
- R3: An access whose region is in neither table is a trigger. It creates a filter entry holding the region tag, the access PC and the access offset. Removing a region that is held only in the filter table discards the entry and produces no record.
- R4: A repeated access to the trigger offset of a filter-held region leaves the entry in the filter table.
- R5: An access to a filter-held region at a different offset moves the entry to the accumulation table. The entry keeps the trigger PC and trigger offset, and its pattern has exactly the trigger bit and the new bit set. Every record sent out has its trigger bit set and has at least two bits set.
- R6: A removal whose region is in the accumulation table sends that region's record and frees the entry. A later removal of the same region, or a removal of a region in neither table, produces no record.
- R7: A new filter entry goes to the lowest-numbered free slot. If no slot is free, the entry replaces a victim chosen by a round-robin pointer, and the victim's generation is dropped without a record.
- R8: A promotion into a full accumulation table replaces a victim chosen by its own round-robin pointer. The victim's record is sent out. The pointer advances by one slot per such replacement and wraps at the table size.
- R9: While cm_valid is high and cm_ready is low, cm_valid stays high and cm_pc, cm_off and cm_pat stay unchanged. in_ready is low whenever cm_valid is high.
- R10: When an access and a removal are accepted in the same cycle, the removal is applied first. An access to the region just removed is therefore a new trigger. At most one record comes out per accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Data access present |
| acc_blk | input | BLK_W | Block address of the access (region tag above, offset below) |
| acc_pc | input | PC_W | PC of the accessing instruction |
| rem_valid | input | 1 | Eviction or invalidation present |
| rem_blk | input | BLK_W | Block address of the removed line |
| in_ready | output | 1 | Both input streams are accepted in this cycle |
| cm_valid | output | 1 | A finished-generation record is offered |
| cm_ready | input | 1 | The consumer takes the record |
| cm_pc | output | PC_W | Trigger PC of the record |
| cm_off | output | OFF_W | Trigger block offset of the record |
| cm_pat | output | 2^OFF_W | Touched-block pattern of the record |

## Verification
The bench builds the block with 8-block regions (OFF_W = 3), a 12-bit block address, a 16-bit PC, a 4-entry filter and a 2-entry accumulation table. With these sizes, a few accesses are enough to fill either table. That puts filter drops, accumulation victim records and the wrap of both round-robin pointers within short, hand-computed sequences. The consumer stalls cm_ready pseudo-randomly, so records are held across several cycles while accesses wait on in_ready.

// File: rtl/sgen_pkg.sv
package sgen_pkg;

    // Commit-port state: accepting inputs, or holding one finished record.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } sgen_state_e;

endpackage

// File: rtl/sgen_first.sv
// Lowest set bit of a vector and its index.
module sgen_first #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/sgen_cam.sv
// Fully associative region table. Two searches per cycle: removal first,
// then access, which never matches the entry the removal is freeing.
// Allocation goes to the lowest free slot, or to the round-robin victim.
module sgen_cam #(
    parameter int N        = 32,
    parameter int TAG_W    = 21,
    parameter int PC_W     = 32,
    parameter int OFF_W    = 5,
    parameter bit KEEP_PAT = 1'b1,
    localparam int PAT_W   = 1 << OFF_W,
    localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    // removal search
    input  logic             rem_en,
    input  logic [TAG_W-1:0] rem_tag,
    output logic             rem_hit,
    output logic [PC_W-1:0]  rem_pc,
    output logic [OFF_W-1:0] rem_off,
    output logic [PAT_W-1:0] rem_pat,
    // access search
    input  logic             acc_en,
    input  logic [TAG_W-1:0] acc_tag,
    output logic             acc_hit,
    output logic [PC_W-1:0]  acc_pc,
    output logic [OFF_W-1:0] acc_off,
    // victim view
    output logic             full,
    output logic [PC_W-1:0]  vic_pc,
    output logic [OFF_W-1:0] vic_off,
    output logic [PAT_W-1:0] vic_pat,
    // updates
    input  logic             hit_free,
    input  logic             set_en,
    input  logic [OFF_W-1:0] set_off,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [PC_W-1:0]  alloc_pc,
    input  logic [OFF_W-1:0] alloc_off,
    input  logic [PAT_W-1:0] alloc_pat
);

    logic [N-1:0]     valid_q;
    logic [TAG_W-1:0] tag_q [N];
    logic [PC_W-1:0]  pc_q  [N];
    logic [OFF_W-1:0] off_q [N];
    logic [IW-1:0]    rr_q;

    logic [N-1:0]     rem_vec, acc_raw, acc_vec, live;
    logic [IW-1:0]    rem_idx, acc_idx, free_idx, slot;
    logic             has_free;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            rem_vec[i] = rem_en && valid_q[i] && (tag_q[i] == rem_tag);
            acc_raw[i] = valid_q[i] && (tag_q[i] == acc_tag);
            acc_vec[i] = acc_en && acc_raw[i] && !rem_vec[i];
        end
        live = valid_q & ~rem_vec;
    end

    sgen_first #(.N(N)) u_rem_enc  (.vec(rem_vec), .found(rem_hit),  .idx(rem_idx));
    sgen_first #(.N(N)) u_acc_enc  (.vec(acc_vec), .found(acc_hit),  .idx(acc_idx));
    sgen_first #(.N(N)) u_free_enc (.vec(~live),   .found(has_free), .idx(free_idx));

    assign full    = !has_free;
    assign slot    = full ? rr_q : free_idx;
    assign rem_pc  = pc_q[rem_idx];
    assign rem_off = off_q[rem_idx];
    assign acc_pc  = pc_q[acc_idx];
    assign acc_off = off_q[acc_idx];
    assign vic_pc  = pc_q[rr_q];
    assign vic_off = off_q[rr_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else begin
            if (rem_hit) valid_q[rem_idx] <= 1'b0;
            if (hit_free && acc_hit) valid_q[acc_idx] <= 1'b0;
            if (alloc_en) valid_q[slot] <= 1'b1;
            if (alloc_en && full) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            tag_q[slot] <= alloc_tag;
            pc_q[slot]  <= alloc_pc;
            off_q[slot] <= alloc_off;
        end
    end

    generate
        if (KEEP_PAT) begin : g_pat
            logic [PAT_W-1:0] pat_q [N];
            always_ff @(posedge clk) begin
                if (alloc_en) pat_q[slot] <= alloc_pat;
                else if (set_en && acc_hit)
                    pat_q[acc_idx] <= pat_q[acc_idx] | (PAT_W'(1) << set_off);
            end
            assign rem_pat = pat_q[rem_idx];
            assign vic_pat = pat_q[rr_q];
        end else begin : g_nopat
            logic unused_pat_in;
            assign unused_pat_in = ^{alloc_pat, set_en, set_off};
            assign rem_pat = '0;
            assign vic_pat = '0;
        end
    endgenerate

    // A region tag lives in at most one entry of a table.
    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_raw)) else $error("duplicate region tag"); // R3
    // A new entry is only made for a region the access did not find.
    AST_NO_DUP_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !acc_hit) else $error("allocation over a hit"); // R3
    // A replaced victim is always a live entry.
    AST_VICTIM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && full) |-> valid_q[rr_q]) else $error("dead victim"); // R7

endmodule

// File: rtl/sgen_train.sv
module sgen_train
    import sgen_pkg::*;
#(
    parameter int BLK_W  = 26,
    parameter int PC_W   = 32,
    parameter int OFF_W  = 5,
    parameter int FLT_N  = 32,
    parameter int ACC_N  = 64,
    localparam int TAG_W = BLK_W - OFF_W,
    localparam int PAT_W = 1 << OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [BLK_W-1:0] acc_blk,
    input  logic [PC_W-1:0]  acc_pc,
    input  logic             rem_valid,
    input  logic [BLK_W-1:0] rem_blk,
    output logic             in_ready,
    output logic             cm_valid,
    input  logic             cm_ready,
    output logic [PC_W-1:0]  cm_pc,
    output logic [OFF_W-1:0] cm_off,
    output logic [PAT_W-1:0] cm_pat
);

    sgen_state_e state_q, state_d;

    logic             acc_go, rem_go;
    logic [TAG_W-1:0] acc_tag, rem_tag;
    logic [OFF_W-1:0] acc_offs;
    logic             unused_rem_off;

    assign acc_go         = acc_valid && in_ready;
    assign rem_go         = rem_valid && in_ready;
    assign acc_tag        = acc_blk[BLK_W-1:OFF_W];
    assign acc_offs       = acc_blk[OFF_W-1:0];
    assign rem_tag        = rem_blk[BLK_W-1:OFF_W];
    assign unused_rem_off = ^rem_blk[OFF_W-1:0];

    // filter table signals
    logic             f_hit;
    logic [PC_W-1:0]  f_pc;
    logic [OFF_W-1:0] f_off;
    logic             f_alloc, promote;
    logic             unused_f_rem_hit, unused_f_full;
    logic [PC_W-1:0]  unused_f_rem_pc, unused_f_vic_pc;
    logic [OFF_W-1:0] unused_f_rem_off, unused_f_vic_off;
    logic [PAT_W-1:0] unused_f_rem_pat, unused_f_vic_pat;

    // accumulation table signals
    logic             a_rem_hit, a_hit, a_full;
    logic [PC_W-1:0]  a_rem_pc, a_vic_pc;
    logic [OFF_W-1:0] a_rem_off, a_vic_off;
    logic [PAT_W-1:0] a_rem_pat, a_vic_pat, new_pat;
    logic [PC_W-1:0]  unused_a_acc_pc;
    logic [OFF_W-1:0] unused_a_acc_off;

    logic rec_rem, rec_vic;

    always_comb begin
        promote = acc_go && !a_hit && f_hit && (f_off != acc_offs);
        f_alloc = acc_go && !a_hit && !f_hit;
        new_pat = (PAT_W'(1) << f_off) | (PAT_W'(1) << acc_offs);
        rec_rem = a_rem_hit;
        rec_vic = promote && a_full;
    end

    sgen_cam #(
        .N(FLT_N), .TAG_W(TAG_W), .PC_W(PC_W), .OFF_W(OFF_W), .KEEP_PAT(1'b0)
    ) u_filter (
        .clk(clk), .rst_n(rst_n),
        .rem_en(rem_go), .rem_tag(rem_tag), .rem_hit(unused_f_rem_hit),
        .rem_pc(unused_f_rem_pc), .rem_off(unused_f_rem_off), .rem_pat(unused_f_rem_pat),
        .acc_en(acc_go), .acc_tag(acc_tag), .acc_hit(f_hit),
        .acc_pc(f_pc), .acc_off(f_off),
        .full(unused_f_full), .vic_pc(unused_f_vic_pc), .vic_off(unused_f_vic_off),
        .vic_pat(unused_f_vic_pat),
        .hit_free(promote), .set_en(1'b0), .set_off('0),
        .alloc_en(f_alloc), .alloc_tag(acc_tag), .alloc_pc(acc_pc),
        .alloc_off(acc_offs), .alloc_pat('0)
    );

    sgen_cam #(
        .N(ACC_N), .TAG_W(TAG_W), .PC_W(PC_W), .OFF_W(OFF_W), .KEEP_PAT(1'b1)
    ) u_accum (
        .clk(clk), .rst_n(rst_n),
        .rem_en(rem_go), .rem_tag(rem_tag), .rem_hit(a_rem_hit),
        .rem_pc(a_rem_pc), .rem_off(a_rem_off), .rem_pat(a_rem_pat),
        .acc_en(acc_go), .acc_tag(acc_tag), .acc_hit(a_hit),
        .acc_pc(unused_a_acc_pc), .acc_off(unused_a_acc_off),
        .full(a_full), .vic_pc(a_vic_pc), .vic_off(a_vic_off), .vic_pat(a_vic_pat),
        .hit_free(1'b0), .set_en(acc_go), .set_off(acc_offs),
        .alloc_en(promote), .alloc_tag(acc_tag), .alloc_pc(f_pc),
        .alloc_off(f_off), .alloc_pat(new_pat)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rec_rem || rec_vic) state_d = ST_SEND;
            ST_SEND: if (cm_ready)           state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = (state_q == ST_IDLE);
        cm_valid = (state_q == ST_SEND);
    end

    // record holding register
    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE) begin
            if (rec_rem) begin
                cm_pc  <= a_rem_pc;
                cm_off <= a_rem_off;
                cm_pat <= a_rem_pat;
            end else if (rec_vic) begin
                cm_pc  <= a_vic_pc;
                cm_off <= a_vic_off;
                cm_pat <= a_vic_pat;
            end
        end
    end

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !cm_ready) |=> cm_valid) else $error("record dropped"); // R9
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !cm_ready) |=> ($stable(cm_pc) && $stable(cm_off) && $stable(cm_pat)))
        else $error("record changed while stalled"); // R9
    AST_TRIGGER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> cm_pat[cm_off]) else $error("trigger bit missing"); // R5
    AST_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> ($countones(cm_pat) >= 2)) else $error("sparse record"); // R5
    AST_ONE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_rem && rec_vic)) else $error("two records in one cycle"); // R10

endmodule

// File: tb/sgen_train_test.sv
`timescale 1ns/1ps
module sgen_train_test;

    localparam int BLK_W = 12;
    localparam int PC_W  = 16;
    localparam int OFF_W = 3;
    localparam int PAT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, rem_valid = 1'b0, cm_ready = 1'b1;
    logic [BLK_W-1:0] acc_blk = '0, rem_blk = '0;
    logic [PC_W-1:0]  acc_pc = '0;
    logic in_ready, cm_valid;
    logic [PC_W-1:0]  cm_pc;
    logic [OFF_W-1:0] cm_off;
    logic [PAT_W-1:0] cm_pat;

    always #10 clk = ~clk;

    sgen_train #(.BLK_W(BLK_W), .PC_W(PC_W), .OFF_W(OFF_W), .FLT_N(4), .ACC_N(2)) uut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_blk(acc_blk), .acc_pc(acc_pc),
        .rem_valid(rem_valid), .rem_blk(rem_blk), .in_ready(in_ready),
        .cm_valid(cm_valid), .cm_ready(cm_ready),
        .cm_pc(cm_pc), .cm_off(cm_off), .cm_pat(cm_pat)
    );

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [OFF_W-1:0] off;
        logic [PAT_W-1:0] pat;
    } rec_t;

    rec_t  exp_q[$];
    string req_q[$];
    string cur_req = "R1";
    int    checks = 0, fails = 0;
    logic  prev_stall = 1'b0;
    rec_t  prev_rec;
    logic [7:0] lfsr = 8'h5a;

    function automatic logic [BLK_W-1:0] ba(int tag, int off);
        return BLK_W'((tag << OFF_W) | off);
    endfunction

    // consumer with pseudo-random stalls
    always @(posedge clk) begin
        #2;
        lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cm_ready = (lfsr[1:0] != 2'b00);
    end

    // monitor: compares records against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                checks++;
                if (!cm_valid || {cm_pc, cm_off, cm_pat} != prev_rec) begin
                    fails++;
                    $display("FAIL R9 stalled record: got v=%0b %h/%0d/%b expected v=1 %h/%0d/%b",
                             cm_valid, cm_pc, cm_off, cm_pat, prev_rec.pc, prev_rec.off, prev_rec.pat);
                end
            end
            if (cm_valid && cm_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL %s unexpected record: got %h/%0d/%b expected none",
                             cur_req, cm_pc, cm_off, cm_pat);
                end else begin
                    rec_t  e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    if ({cm_pc, cm_off, cm_pat} != e) begin
                        fails++;
                        $display("FAIL %s record: got pc=%h off=%0d pat=%b expected pc=%h off=%0d pat=%b",
                                 r, cm_pc, cm_off, cm_pat, e.pc, e.off, e.pat);
                    end
                end
            end
            prev_stall = cm_valid && !cm_ready;
            prev_rec   = {cm_pc, cm_off, cm_pat};
        end
    end

    task automatic send(input bit av, input logic [BLK_W-1:0] ab, input logic [PC_W-1:0] ap,
                        input bit rv, input logic [BLK_W-1:0] rb);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        acc_valid = av; acc_blk = ab; acc_pc = ap;
        rem_valid = rv; rem_blk = rb;
        @(negedge clk);
        acc_valid = 1'b0; rem_valid = 1'b0;
    endtask

    task automatic access(input int tag, input int off, input int pc);
        send(1'b1, ba(tag, off), PC_W'(pc), 1'b0, '0);
    endtask

    task automatic remove(input int tag, input int off);
        send(1'b0, '0, '0, 1'b1, ba(tag, off));
    endtask

    task automatic expect_rec(input int pc, input int off, input int pat, input string r);
        exp_q.push_back({PC_W'(pc), OFF_W'(off), PAT_W'(pat)});
        req_q.push_back(r);
    endtask

    // wait for all expected records, then check the port stays quiet
    task automatic drain_quiet(input string r);
        while (exp_q.size() != 0 || cm_valid) @(negedge clk);
        repeat (4) @(negedge clk);
        checks++;
        if (cm_valid || exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s quiet check: got cm_valid=%0b pending=%0d expected 0/0",
                     r, cm_valid, exp_q.size());
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: got pending=%0d expected completion", exp_q.size());
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (in_ready !== 1'b1 || cm_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got in_ready=%0b cm_valid=%0b expected 1/0", in_ready, cm_valid);
        end

        // R3: single touch, then removal: dropped silently
        cur_req = "R3";
        access(1, 2, 'h100);
        remove(1, 5);
        drain_quiet("R3");

        // R4: same offset twice stays in the filter
        cur_req = "R4";
        access(2, 1, 'h200);
        access(2, 1, 'h201);
        remove(2, 0);
        drain_quiet("R4");

        // R5/R2: promotion and bit accumulation, repeated bit idempotent
        cur_req = "R5";
        access(3, 4, 'h300);
        access(3, 6, 'h301);
        access(3, 0, 'h302);
        access(3, 6, 'h303);
        expect_rec('h300, 4, 'h51, "R2/R5");
        remove(3, 7);
        drain_quiet("R6");
        // R6: freed region and unknown region give nothing
        cur_req = "R6";
        remove(3, 1);
        remove(9, 0);
        drain_quiet("R6");

        // R10: removal and access of same region in one cycle
        cur_req = "R10";
        access(4, 1, 'h400);
        access(4, 2, 'h401);
        expect_rec('h400, 1, 'h06, "R10 removal first");
        send(1'b1, ba(4, 5), PC_W'('h410), 1'b1, ba(4, 3));
        access(4, 7, 'h411);
        expect_rec('h410, 5, 'hA0, "R10 new trigger");
        remove(4, 0);
        drain_quiet("R10");

        // R7: filter full, round-robin drop
        cur_req = "R7";
        access(10, 0, 'hA0);
        access(11, 0, 'hA1);
        access(12, 0, 'hA2);
        access(13, 0, 'hA3);
        access(14, 0, 'hA4);   // drops region 10 (slot 0)
        access(10, 1, 'hB0);   // new trigger, drops region 11 (slot 1)
        access(10, 3, 'hB1);
        expect_rec('hB0, 1, 'h0A, "R7 dropped trigger replaced");
        remove(10, 0);
        access(11, 2, 'hB2);   // region 11 must be a fresh trigger
        access(12, 5, 'hB3);
        expect_rec('hA2, 0, 'h21, "R7 surviving entry");
        remove(12, 0);
        remove(11, 0);
        remove(13, 0);
        remove(14, 0);
        drain_quiet("R7");

        // R8: accumulation full, victims sent out round-robin
        cur_req = "R8";
        access(20, 0, 'hC0);
        access(20, 1, 'hC5);
        access(21, 2, 'hC1);
        access(21, 3, 'hC6);
        expect_rec('hC0, 0, 'h03, "R8 victim slot 0");
        access(22, 4, 'hC2);
        access(22, 5, 'hC7);
        expect_rec('hC1, 2, 'h0C, "R8 victim slot 1");
        access(23, 6, 'hC3);
        access(23, 7, 'hC8);
        drain_quiet("R8");
        access(20, 1, 'hC4);   // region 20 gone: fresh trigger
        remove(20, 0);
        drain_quiet("R8");
        expect_rec('hC2, 4, 'h30, "R8 remaining entry");
        remove(22, 0);
        expect_rec('hC3, 6, 'hC0, "R8 remaining entry");
        remove(23, 0);
        drain_quiet("R8");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule